// File: doc/BRIEF.md
# Bang-Bang Clock Cleanup Loop Controller

This block is the digital control core of a wideband clock cleanup loop that removes high-frequency jitter from a received forwarded clock. It takes one early/late decision per oscillator cycle from a phase comparator, plus a small vector of extra feedback-phase comparisons. From these it builds three control outputs. The first is a proportional frequency-bang command sent straight to the oscillator. The second is an integral word that a first-order sigma-delta modulator reduces to a 1-bit stream for a DAC. The third is a coarse frequency code that a one-shot calibration search sets.

Loop bandwidth is set by two programmable bang magnitudes. An optional voting filter, which lowers bandwidth, can be placed in front of the proportional path. With the filter in bypass, a decision reaches the bang command after two register stages. The integral path always works on the raw decisions, whatever the filter setting.

Top module: `bbcl_ctrl`

## Requirements
- R1: A decision is "up" when `pd_late`=1 and `pd_early`=0. It is "down" when `pd_early`=1 and `pd_late`=0. It is "hold" when both inputs are equal.
- R2: With `avg_sel`=0 (bypass), a decision sampled at clock edge k appears on `prop_code`/`freq_step` after edge k+1.
- R3: `prop_code` encodes HOLD=0, UP1=1, UP2=2, DN1=3, DN2=4. `freq_step` is 0, +a, +(a+b), -a or -(a+b) for these codes, where a=`bang_a` and b=`bang_b`, taken as signed and registered together with the code.
- R4: An up decision uses the large step (UP2) when at least two bits of `pd_xlate` are set. A down decision uses DN2 when at least two bits of `pd_xearly` are set. Otherwise the small step is used.
- R5: `avg_sel` values 0, 1, 2 and 3 select a vote over the latest 1, 2, 4 or 8 decisions. Up counts +1, down counts -1 and hold counts 0. A positive sum drives up, a negative sum drives down and zero drives hold. The large step is kept only when the newest decision is large and agrees with the vote.
- R6: `integ_word` resets to 8192. Each raw decision adds +1 (up) or -1 (down), whatever the filter setting. The word saturates at 0 and 16383 and never wraps.
- R7: `sd_bit` is the carry of a 14-bit first-order accumulator that adds `integ_word` every cycle. Its ones density is `integ_word`/16384, and it stays 0 while `integ_word` is 0.
- R8: `coarse_code` resets to 32. Calibration starts only once `cal_en` is seen high, and it then latches the MSB of `integ_word`. Every 16 cycles it steps `coarse_code` by one: up if the latched MSB is 1, down if it is 0. When the MSB differs from the latched value, or the code reaches its end, it freezes and raises `cal_done` until reset.
- R9: Synchronous reset `rst` gives `prop_code`=HOLD, `freq_step`=0, `integ_word`=8192, `sd_bit`=0, `coarse_code`=32 and `cal_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_early | input | 1 | Primary comparison: feedback early |
| pd_late | input | 1 | Primary comparison: feedback late |
| pd_xearly | input | 4 | Extra-phase comparisons voting early |
| pd_xlate | input | 4 | Extra-phase comparisons voting late |
| avg_sel | input | 2 | Vote depth select (1, 2, 4, 8) |
| bang_a | input | 8 | First bang magnitude |
| bang_b | input | 8 | Second bang magnitude |
| cal_en | input | 1 | Start coarse calibration |
| prop_code | output | 3 | Proportional bang code |
| freq_step | output | 10 | Signed frequency bang value |
| integ_word | output | 14 | Integral path word |
| sd_bit | output | 1 | Sigma-delta DAC bit |
| coarse_code | output | 6 | Coarse frequency code |
| cal_done | output | 1 | Calibration finished and frozen |

## Verification
A table of primary and extra-phase patterns covers the decode. It separates agreeing extras from disagreeing ones, a single agreeing extra from two, and conflicting primary bits from idle ones, and it checks step values at small and full-scale bang magnitudes. Single and paired opposite pulses at each vote depth show the filter's stretching and cancellation, and a big pulse at depth 2 shows the large step dropping once the pulse is no longer the newest decision. Long one-way runs drive the integral word into both saturation limits, and sigma-delta density is measured at mid, full and zero scale. A held mid-scale word followed by a downward push shows calibration stepping and then freezing.

// File: rtl/bbcl_pkg.sv
package bbcl_pkg;

    localparam int P_N_EXTRA   = 4;
    localparam int P_W_BANG    = 8;
    localparam int P_W_INT     = 14;
    localparam int P_W_COARSE  = 6;
    localparam int P_DEPTH_MAX = 8;
    localparam int P_CAL_WAIT  = 16;

    typedef enum logic [2:0] {
        PC_HOLD = 3'd0,
        PC_UP1  = 3'd1,
        PC_UP2  = 3'd2,
        PC_DN1  = 3'd3,
        PC_DN2  = 3'd4
    } pcode_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic big;
    } decision_t;

    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_RUN  = 2'd1,
        CAL_DONE = 2'd2
    } cal_state_e;

    function automatic pcode_e make_code(input logic up, input logic dn, input logic big);
        if (up)      return big ? PC_UP2 : PC_UP1;
        else if (dn) return big ? PC_DN2 : PC_DN1;
        else         return PC_HOLD;
    endfunction

endpackage

// File: rtl/bbcl_decode.sv
module bbcl_decode
    import bbcl_pkg::*;
#(
    parameter int N_EXTRA = P_N_EXTRA
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               early,
    input  logic               late,
    input  logic [N_EXTRA-1:0] x_early,
    input  logic [N_EXTRA-1:0] x_late,
    output decision_t          dec_q
);

    decision_t dec_d;

    always_comb begin
        dec_d.up  = late & ~early;
        dec_d.dn  = early & ~late;
        dec_d.big = (dec_d.up && ($countones(x_late) >= 2)) ||
                    (dec_d.dn && ($countones(x_early) >= 2));
    end

    always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else     dec_q <= dec_d;
    end

    // R1: equal primary bits never produce a direction
    p_equal_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (early == late) |=> (!dec_q.up && !dec_q.dn));

endmodule

// File: rtl/bbcl_vote_filter.sv
module bbcl_vote_filter
    import bbcl_pkg::*;
#(
    parameter int W_BANG    = P_W_BANG,
    parameter int DEPTH_MAX = P_DEPTH_MAX
) (
    input  logic                     clk,
    input  logic                     rst,
    input  decision_t                dec,
    input  logic [1:0]               depth_sel,
    input  logic [W_BANG-1:0]        bang_a,
    input  logic [W_BANG-1:0]        bang_b,
    output pcode_e                   pcode,
    output logic signed [W_BANG+1:0] freq_step
);

    localparam int W_SUM  = $clog2(DEPTH_MAX) + 2;
    localparam int W_STEP = W_BANG + 2;

    decision_t hist_q [DEPTH_MAX-1];
    decision_t win    [DEPTH_MAX];

    assign win[0] = dec;
    for (genvar g = 1; g < DEPTH_MAX; g++) begin : g_win
        assign win[g] = hist_q[g-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH_MAX - 1; i++) hist_q[i] <= '0;
        end else begin
            hist_q[0] <= dec;
            for (int i = 1; i < DEPTH_MAX - 1; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    logic signed [W_SUM-1:0] sum;
    logic                    v_up, v_dn, v_big;
    logic [W_STEP-1:0]       mag, step_d;

    always_comb begin
        sum = '0;
        for (int i = 0; i < DEPTH_MAX; i++) begin
            if (i < (1 << depth_sel)) begin
                if (win[i].up)      sum = sum + W_SUM'(1);
                else if (win[i].dn) sum = sum - W_SUM'(1);
            end
        end
        v_up  = sum > 0;
        v_dn  = sum < 0;
        v_big = dec.big && ((v_up && dec.up) || (v_dn && dec.dn));
        mag   = v_big ? ({2'b00, bang_a} + {2'b00, bang_b}) : {2'b00, bang_a};
        if (v_up)      step_d = mag;
        else if (v_dn) step_d = -mag;
        else           step_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcode     <= PC_HOLD;
            freq_step <= '0;
        end else begin
            pcode     <= make_code(v_up, v_dn, v_big);
            freq_step <= $signed(step_d);
        end
    end

    // R2: in bypass an up decision becomes an up code on the next edge
    p_bypass_up_r2: assert property (@(posedge clk) disable iff (rst)
        (depth_sel == 2'd0 && dec.up) |=> (pcode == PC_UP1 || pcode == PC_UP2));

    // R3: large up step equals the sum of both magnitudes
    p_big_step_r3: assert property (@(posedge clk) disable iff (rst)
        (pcode == PC_UP2) |-> ($unsigned(freq_step) ==
            ({2'b00, $past(bang_a)} + {2'b00, $past(bang_b)})));

    // R3: hold code carries no step
    p_hold_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (pcode == PC_HOLD) |-> (freq_step == '0));

endmodule

// File: rtl/bbcl_integ_sd.sv
module bbcl_integ_sd
    import bbcl_pkg::*;
#(
    parameter int W_INT = P_W_INT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [W_INT-1:0] integ_q,
    output logic             sd_bit
);

    localparam logic [W_INT-1:0] INT_MID = 1 << (W_INT - 1);
    localparam logic [W_INT-1:0] INT_MAX = '1;

    logic [W_INT-1:0] sd_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= INT_MID;
        end else if (step_up && integ_q != INT_MAX) begin
            integ_q <= integ_q + 1'b1;
        end else if (step_dn && integ_q != '0) begin
            integ_q <= integ_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) {sd_bit, sd_acc} <= '0;
        else     {sd_bit, sd_acc} <= {1'b0, sd_acc} + {1'b0, integ_q};
    end

    // R6: the word moves by at most one per cycle, so it cannot wrap
    p_int_step_r6: assert property (@(posedge clk) disable iff (rst)
        ((int'(integ_q) - int'($past(integ_q))) <= 1) &&
        ((int'(integ_q) - int'($past(integ_q))) >= -1));

    // R7: a zero word yields no modulator output
    p_sd_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (integ_q == '0) |=> !sd_bit);

endmodule

// File: rtl/bbcl_cal.sv
module bbcl_cal
    import bbcl_pkg::*;
#(
    parameter int W_COARSE = P_W_COARSE,
    parameter int CAL_WAIT = P_CAL_WAIT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cal_en,
    input  logic                integ_msb,
    output logic [W_COARSE-1:0] coarse_q,
    output logic                done
);

    localparam int                  W_CNT     = $clog2(CAL_WAIT);
    localparam logic [W_COARSE-1:0] COARSE_MID = 1 << (W_COARSE - 1);
    localparam logic [W_COARSE-1:0] COARSE_MAX = '1;

    cal_state_e       state;
    logic             ref_msb;
    logic [W_CNT-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CAL_IDLE;
            ref_msb  <= 1'b0;
            cnt      <= '0;
            coarse_q <= COARSE_MID;
        end else begin
            case (state)
                CAL_IDLE: if (cal_en) begin
                    state   <= CAL_RUN;
                    ref_msb <= integ_msb;
                    cnt     <= '0;
                end
                CAL_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == W_CNT'(CAL_WAIT - 1)) begin
                        if (integ_msb != ref_msb)                 state <= CAL_DONE;
                        else if (ref_msb && coarse_q == COARSE_MAX) state <= CAL_DONE;
                        else if (!ref_msb && coarse_q == '0)       state <= CAL_DONE;
                        else if (ref_msb) coarse_q <= coarse_q + 1'b1;
                        else              coarse_q <= coarse_q - 1'b1;
                    end
                end
                default: state <= CAL_DONE;
            endcase
        end
    end

    assign done = (state == CAL_DONE);

    // R8: once finished, the coarse code is frozen
    p_cal_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(coarse_q) && done));

    // R8: the coarse code moves by at most one step per cycle
    p_coarse_step_r8: assert property (@(posedge clk) disable iff (rst)
        ((int'(coarse_q) - int'($past(coarse_q))) <= 1) &&
        ((int'(coarse_q) - int'($past(coarse_q))) >= -1));

endmodule

// File: rtl/bbcl_ctrl.sv
module bbcl_ctrl
    import bbcl_pkg::*;
#(
    parameter int N_EXTRA   = P_N_EXTRA,
    parameter int W_BANG    = P_W_BANG,
    parameter int W_INT     = P_W_INT,
    parameter int W_COARSE  = P_W_COARSE,
    parameter int DEPTH_MAX = P_DEPTH_MAX,
    parameter int CAL_WAIT  = P_CAL_WAIT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pd_early,
    input  logic                     pd_late,
    input  logic [N_EXTRA-1:0]       pd_xearly,
    input  logic [N_EXTRA-1:0]       pd_xlate,
    input  logic [1:0]               avg_sel,
    input  logic [W_BANG-1:0]        bang_a,
    input  logic [W_BANG-1:0]        bang_b,
    input  logic                     cal_en,
    output logic [2:0]               prop_code,
    output logic signed [W_BANG+1:0] freq_step,
    output logic [W_INT-1:0]         integ_word,
    output logic                     sd_bit,
    output logic [W_COARSE-1:0]      coarse_code,
    output logic                     cal_done
);

    decision_t dec;
    pcode_e    pcode;

    bbcl_decode #(.N_EXTRA(N_EXTRA)) u_decode (
        .clk(clk), .rst(rst), .early(pd_early), .late(pd_late),
        .x_early(pd_xearly), .x_late(pd_xlate), .dec_q(dec)
    );

    bbcl_vote_filter #(.W_BANG(W_BANG), .DEPTH_MAX(DEPTH_MAX)) u_filter (
        .clk(clk), .rst(rst), .dec(dec), .depth_sel(avg_sel),
        .bang_a(bang_a), .bang_b(bang_b), .pcode(pcode), .freq_step(freq_step)
    );

    bbcl_integ_sd #(.W_INT(W_INT)) u_integ (
        .clk(clk), .rst(rst), .step_up(dec.up), .step_dn(dec.dn),
        .integ_q(integ_word), .sd_bit(sd_bit)
    );

    bbcl_cal #(.W_COARSE(W_COARSE), .CAL_WAIT(CAL_WAIT)) u_cal (
        .clk(clk), .rst(rst), .cal_en(cal_en), .integ_msb(integ_word[W_INT-1]),
        .coarse_q(coarse_code), .done(cal_done)
    );

    assign prop_code = pcode;

endmodule

// File: tb/test_bbcl_ctrl.sv
module test_bbcl_ctrl;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              e = 1'b0, l = 1'b0, cen = 1'b0;
    logic [3:0]        xe = '0, xl = '0;
    logic [1:0]        sel = '0;
    logic [7:0]        ba = 8'd10, bb = 8'd5;
    logic [2:0]        pc;
    logic signed [9:0] fs;
    logic [13:0]       iw;
    logic              sd, cdone;
    logic [5:0]        cc;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    bbcl_ctrl i_bbcl_ctrl (
        .clk(clk), .rst(rst), .pd_early(e), .pd_late(l), .pd_xearly(xe), .pd_xlate(xl),
        .avg_sel(sel), .bang_a(ba), .bang_b(bb), .cal_en(cen),
        .prop_code(pc), .freq_step(fs), .integ_word(iw), .sd_bit(sd),
        .coarse_code(cc), .cal_done(cdone)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int step_of(input int code, input int a, input int b);
        case (code)
            1: return a;
            2: return a + b;
            3: return -a;
            4: return -(a + b);
            default: return 0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; e = 0; l = 0; xe = '0; xl = '0; sel = '0; cen = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // {early, late, xearly[3:0], xlate[3:0], expected code[2:0]}
    localparam logic [12:0] VEC [10] = '{
        {1'b0, 1'b1, 4'b0000, 4'b0000, 3'd1},
        {1'b0, 1'b1, 4'b0000, 4'b0011, 3'd2},
        {1'b0, 1'b1, 4'b0000, 4'b0001, 3'd1},
        {1'b1, 1'b0, 4'b0110, 4'b0000, 3'd4},
        {1'b1, 1'b0, 4'b1000, 4'b0000, 3'd3},
        {1'b1, 1'b1, 4'b0000, 4'b1111, 3'd0},
        {1'b0, 1'b0, 4'b0000, 4'b1111, 3'd0},
        {1'b0, 1'b1, 4'b1111, 4'b0000, 3'd1},
        {1'b1, 1'b0, 4'b1111, 4'b0000, 3'd4},
        {1'b0, 1'b1, 4'b0000, 4'b1111, 3'd2}
    };

    task automatic pulse_test(input logic [1:0] s, input bit pair, output int ups, output int dns);
        do_reset();
        sel = s; l = 1'b1;
        ups = 0; dns = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (pc == 3'd1 || pc == 3'd2) ups++;
            if (pc == 3'd3 || pc == 3'd4) dns++;
            if (i == 0) begin l = 1'b0; e = pair; end
            if (i == 1) e = 1'b0;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int ups, dns, ones;

        // R9: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(pc == 3'd0, "R9 code", pc, 0);
        chk(fs == 0, "R9 step", fs, 0);
        chk(iw == 14'd8192, "R9 integ", iw, 8192);
        chk(sd == 1'b0, "R9 sd", sd, 0);
        chk(cc == 6'd32, "R9 coarse", cc, 32);
        chk(cdone == 1'b0, "R9 done", cdone, 0);
        rst = 1'b0;

        // R1 R2 R3 R4: table walk in bypass
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            {e, l, xe, xl} = VEC[k][12:3];
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            chk(pc == VEC[k][2:0], "R1/R4 code", pc, VEC[k][2:0]);
            chk(int'(fs) == step_of(VEC[k][2:0], 10, 5), "R3 step", fs,
                step_of(VEC[k][2:0], 10, 5));
        end

        // R3: other magnitudes incl. full scale
        @(negedge clk);
        ba = 8'd100; bb = 8'd27; e = 1; l = 0; xe = 4'b0011; xl = '0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(int'(fs) == -127, "R3 dn2 mag", fs, -127);
        ba = 8'd255; bb = 8'd255; e = 0; l = 1; xe = '0; xl = 4'b1100;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(int'(fs) == 510, "R3 full up2", fs, 510);
        e = 1; l = 0; xe = 4'b1100; xl = '0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(int'(fs) == -510, "R3 full dn2", fs, -510);
        ba = 8'd10; bb = 8'd5;

        // R2: exact latency, sample one edge too early then on time
        do_reset();
        l = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(pc == 3'd0, "R2 not yet", pc, 0);
        @(posedge clk); @(negedge clk);
        chk(pc == 3'd1, "R2 arrived", pc, 1);

        // R5: vote depth stretches a single pulse
        pulse_test(2'd0, 1'b0, ups, dns);
        chk(ups == 1, "R5 depth1 ups", ups, 1);
        pulse_test(2'd2, 1'b0, ups, dns);
        chk(ups == 4, "R5 depth4 ups", ups, 4);
        pulse_test(2'd3, 1'b0, ups, dns);
        chk(ups == 8, "R5 depth8 ups", ups, 8);
        chk(iw == 14'd8193, "R6 raw decisions under filter", iw, 8193);
        pulse_test(2'd2, 1'b1, ups, dns);
        chk(ups == 1, "R5 pair ups", ups, 1);
        chk(dns == 1, "R5 pair dns", dns, 1);
        chk(iw == 14'd8192, "R6 up then down", iw, 8192);

        // R5: large step only while newest decision is large
        do_reset();
        sel = 2'd1; l = 1; xl = 4'b0011;
        @(negedge clk);
        l = 0; xl = '0;
        @(negedge clk);
        chk(pc == 3'd2, "R5 big newest", pc, 2);
        @(negedge clk);
        chk(pc == 3'd1, "R5 big dropped", pc, 1);
        @(negedge clk);
        chk(pc == 3'd0, "R5 window passed", pc, 0);

        // R7: mid-scale density
        do_reset();
        repeat (3) @(negedge clk);
        ones = 0;
        for (int i = 0; i < 16; i++) begin @(negedge clk); ones += int'(sd); end
        chk(ones == 8, "R7 mid density", ones, 8);

        // R8: no calibration without enable
        repeat (40) @(negedge clk);
        chk(cc == 6'd32, "R8 idle coarse", cc, 32);
        chk(cdone == 1'b0, "R8 idle done", cdone, 0);

        // R8: calibration steps up, then freezes on crossing
        cen = 1'b1;
        repeat (88) @(posedge clk);
        @(negedge clk);
        chk(cc == 6'd37, "R8 stepping", cc, 37);
        chk(cdone == 1'b0, "R8 still running", cdone, 0);
        e = 1'b1;
        @(negedge clk);
        e = 1'b0;
        repeat (20) @(negedge clk);
        chk(cdone == 1'b1, "R8 done", cdone, 1);
        chk(cc == 6'd37, "R8 frozen", cc, 37);
        repeat (40) @(negedge clk);
        chk(cc == 6'd37, "R8 still frozen", cc, 37);
        cen = 1'b0;

        // R6 R7: upper saturation
        do_reset();
        l = 1'b1;
        repeat (8300) @(negedge clk);
        chk(iw == 14'd16383, "R6 top saturate", iw, 16383);
        ones = 0;
        for (int i = 0; i < 32; i++) begin @(negedge clk); ones += int'(sd); end
        chk(iw == 14'd16383, "R6 no wrap high", iw, 16383);
        chk(ones >= 31, "R7 full density", ones, 31);

        // R6 R7: lower saturation
        l = 1'b0; e = 1'b1;
        repeat (16500) @(negedge clk);
        chk(iw == 14'd0, "R6 bottom saturate", iw, 0);
        ones = 0;
        for (int i = 0; i < 16; i++) begin @(negedge clk); ones += int'(sd); end
        chk(iw == 14'd0, "R6 no wrap low", iw, 0);
        chk(ones == 0, "R7 zero density", ones, 0);
        e = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule